// File: doc/BRIEF.md
# Burst Read Transfer Splitter

This block turns one client read of arbitrary byte length into a sequence of bus read requests sized to the bus. The client hands over a byte start address and a byte count. The block then walks the covered native words in ascending order. A start that is not word aligned gets a single-beat request with a partial byte-enable mask. An end that is not word aligned gets the same treatment. Every word in between is requested as a fixed-length burst of at most `MAX_BURST` beats.

Each data beat that the bus returns is passed straight into a downstream read buffer. The buffer reports how many entries it has free. A request is only posted when that free count can hold the request's beats plus every beat already requested but not yet returned. When all beats have been written, a one-cycle done pulse tells the client that the command has finished. An error flag beside the pulse reports whether any beat came back with a bus error.

Top module: `burst_read_splitter`

## Requirements
- R1: `cmd_ready` is high exactly while no command is in progress, including right after reset. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` stays low while any request is posted. The byte count must be at least 1.
- R2: If the start address is not aligned to `DATA_W/8` bytes, the first request has `req_beats` = 1. Its `req_be` has bit i set for byte lanes i at or above the start offset. Bit i of `req_be` is byte lane i, and `req_addr` is always the word-aligned byte address.
- R3: If the last byte does not fall on the top lane of its word, the final request is a single beat. Its `req_be` bits run from lane 0 up to the end offset. When the whole transfer lies in one word, a single request carries only the lanes from the start offset to the end offset.
- R4: Aligned middle words are requested in ascending address order as bursts of `MAX_BURST` beats. The remaining count, if it is 2 or more, goes out as one shorter burst. Every burst has all byte enables set.
- R5: An aligned middle remainder of exactly one word is requested as a single beat with all byte enables set.
- R6: A posted request keeps `req_valid`, `req_addr`, `req_beats` and `req_be` unchanged until the cycle in which `req_ack` is seen. `req_valid` drops on the following cycle.
- R7: A request is posted only if `buf_free` is at least its beat count plus the number of beats already acknowledged but not yet returned.
- R8: Every returned beat (`rd_valid`) of a running command is written to the buffer in the same cycle (`buf_wr`), with `buf_data` equal to `rd_data`. The beats appear in request order.
- R9: One cycle after the last beat of the last request has been written, `done` is high for exactly one cycle. `err` is high with it if any beat of that command came with `rd_err`, and low otherwise. The flag is cleared by the next command.
- R10: `req_beats` is the beat count of the posted request (1 means a single beat) and always lies between 1 and `MAX_BURST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Client command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Byte count, nonzero |
| req_valid | output | 1 | Bus read request posted |
| req_ack | input | 1 | Bus accepted the posted request |
| req_addr | output | ADDR_W | Word-aligned byte address of the request |
| req_beats | output | clog2(MAX_BURST+1) | Beats in the request |
| req_be | output | DATA_W/8 | Byte lane enables for single beats |
| rd_valid | input | 1 | Read data beat returned by the bus |
| rd_data | input | DATA_W | Returned data |
| rd_err | input | 1 | Bus error on this beat |
| buf_wr | output | 1 | Write strobe into the read buffer |
| buf_data | output | DATA_W | Data written into the read buffer |
| buf_free | input | FREE_W | Free entries in the read buffer |
| done | output | 1 | Command finished, one-cycle pulse |
| err | output | 1 | Error status, valid with done |

## Verification
Some rules are checked on every cycle. These are: the request hold rule, the beat-count range, full enables on bursts, the buffer-room rule with the outstanding-beat count, `cmd_ready` being low during a posted request, and the single-cycle done pulse. The bench scenarios are what show the split itself. They show the partial masks at an unaligned head and tail, the one-word remainder becoming a single beat, and the order of requests and data for transfers of many sizes and offsets. They also show that an error on one beat is reported only with that command, and that a starved buffer holds back a burst until space appears.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } brs_state_e;
endpackage

// File: rtl/brs_req_plan.sv
// Sizes the next request from the words still to be requested.
module brs_req_plan #(
  parameter int BYTES     = 4,
  parameter int MAX_BURST = 16,
  parameter int CNT_W     = 17,
  parameter int BEAT_W    = 5
) (
  input  logic              first_i,
  input  logic              head_unal_i,
  input  logic              tail_unal_i,
  input  logic [CNT_W-1:0]  rem_i,
  input  logic [BYTES-1:0]  first_be_i,
  input  logic [BYTES-1:0]  last_be_i,
  output logic [BEAT_W-1:0] beats_o,
  output logic [BYTES-1:0]  be_o
);
  logic [CNT_W-1:0] body;
  logic [BYTES-1:0] lo_mask;
  logic [BYTES-1:0] hi_mask;

  // aligned words left before an unaligned tail word
  assign body = rem_i - CNT_W'(tail_unal_i);

  always_comb begin
    if (first_i && head_unal_i) begin
      beats_o = BEAT_W'(1);
    end else if (body == '0) begin
      beats_o = BEAT_W'(1);
    end else if (body >= CNT_W'(MAX_BURST)) begin
      beats_o = BEAT_W'(MAX_BURST);
    end else begin
      beats_o = body[BEAT_W-1:0];
    end
  end

  always_comb begin
    lo_mask = first_i ? first_be_i : {BYTES{1'b1}};
    hi_mask = (rem_i == CNT_W'(1)) ? last_be_i : {BYTES{1'b1}};
    if (beats_o == BEAT_W'(1)) begin
      be_o = lo_mask & hi_mask;
    end else begin
      be_o = {BYTES{1'b1}};
    end
  end
endmodule

// File: rtl/brs_credit.sv
// Tracks beats requested but not yet returned and judges buffer room.
module brs_credit #(
  parameter int BEAT_W = 5,
  parameter int FREE_W = 8,
  parameter int OUT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en_i,
  input  logic [BEAT_W-1:0] add_beats_i,
  input  logic              sub_en_i,
  input  logic [BEAT_W-1:0] need_i,
  input  logic [FREE_W-1:0] free_i,
  output logic [OUT_W-1:0]  out_cnt_o,
  output logic              room_o
);
  logic [OUT_W-1:0] out_q;
  logic [OUT_W-1:0] out_d;
  logic [OUT_W:0]   demand;

  always_comb begin
    out_d = out_q;
    if (add_en_i) begin
      out_d = out_d + OUT_W'(add_beats_i);
    end
    if (sub_en_i) begin
      out_d = out_d - OUT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (add_en_i || sub_en_i) begin
      out_q <= out_d;
    end
  end

  assign demand    = (OUT_W+1)'(need_i) + (OUT_W+1)'(out_q);
  assign room_o    = (OUT_W+1)'(free_i) >= demand;
  assign out_cnt_o = out_q;
endmodule

// File: rtl/burst_read_splitter.sv
module burst_read_splitter #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 16,
  parameter int FREE_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [ADDR_W-1:0]              cmd_addr,
  input  logic [LEN_W-1:0]               cmd_len,
  output logic                           req_valid,
  input  logic                           req_ack,
  output logic [ADDR_W-1:0]              req_addr,
  output logic [$clog2(MAX_BURST+1)-1:0] req_beats,
  output logic [DATA_W/8-1:0]            req_be,
  input  logic                           rd_valid,
  input  logic [DATA_W-1:0]              rd_data,
  input  logic                           rd_err,
  output logic                           buf_wr,
  output logic [DATA_W-1:0]              buf_data,
  input  logic [FREE_W-1:0]              buf_free,
  output logic                           done,
  output logic                           err
);
  import brs_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int OFFW   = $clog2(BYTES);
  localparam int BEAT_W = $clog2(MAX_BURST + 1);
  localparam int CNT_W  = LEN_W + 1;
  localparam int WORD_W = ADDR_W - OFFW;
  localparam int OUT_W  = FREE_W + 1;

  brs_state_e        state_q, state_d;
  logic [WORD_W-1:0] cur_wd_q, cur_wd_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              first_q, first_d;
  logic              head_unal_q, head_unal_d;
  logic              tail_unal_q, tail_unal_d;
  logic [BYTES-1:0]  first_be_q, first_be_d;
  logic [BYTES-1:0]  last_be_q, last_be_d;
  logic              req_valid_q, req_valid_d;
  logic [BEAT_W-1:0] req_beats_q, req_beats_d;
  logic [BYTES-1:0]  req_be_q, req_be_d;
  logic              err_q, err_d;
  logic              done_q, done_d;

  logic [ADDR_W-1:0] end_addr;
  logic [WORD_W-1:0] word_span;
  logic [BEAT_W-1:0] plan_beats;
  logic [BYTES-1:0]  plan_be;
  logic [OUT_W-1:0]  out_cnt;
  logic              room;
  logic              acked;
  logic              wr_beat;

  assign end_addr  = cmd_addr + ADDR_W'(cmd_len) - ADDR_W'(1);
  assign word_span = end_addr[ADDR_W-1:OFFW] - cmd_addr[ADDR_W-1:OFFW] + WORD_W'(1);
  assign acked     = req_valid_q && req_ack;
  assign wr_beat   = rd_valid && (state_q == ST_RUN);

  brs_req_plan #(
    .BYTES     (BYTES),
    .MAX_BURST (MAX_BURST),
    .CNT_W     (CNT_W),
    .BEAT_W    (BEAT_W)
  ) plan_i (
    .first_i     (first_q),
    .head_unal_i (head_unal_q),
    .tail_unal_i (tail_unal_q),
    .rem_i       (rem_q),
    .first_be_i  (first_be_q),
    .last_be_i   (last_be_q),
    .beats_o     (plan_beats),
    .be_o        (plan_be)
  );

  brs_credit #(
    .BEAT_W (BEAT_W),
    .FREE_W (FREE_W),
    .OUT_W  (OUT_W)
  ) credit_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .add_en_i    (acked),
    .add_beats_i (req_beats_q),
    .sub_en_i    (wr_beat),
    .need_i      (plan_beats),
    .free_i      (buf_free),
    .out_cnt_o   (out_cnt),
    .room_o      (room)
  );

  always_comb begin
    state_d     = state_q;
    cur_wd_d    = cur_wd_q;
    rem_d       = rem_q;
    first_d     = first_q;
    head_unal_d = head_unal_q;
    tail_unal_d = tail_unal_q;
    first_be_d  = first_be_q;
    last_be_d   = last_be_q;
    req_valid_d = req_valid_q;
    req_beats_d = req_beats_q;
    req_be_d    = req_be_q;
    err_d       = err_q;
    done_d      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          state_d     = ST_RUN;
          cur_wd_d    = cmd_addr[ADDR_W-1:OFFW];
          rem_d       = CNT_W'(word_span);
          first_d     = 1'b1;
          head_unal_d = |cmd_addr[OFFW-1:0];
          tail_unal_d = end_addr[OFFW-1:0] != {OFFW{1'b1}};
          first_be_d  = {BYTES{1'b1}} << cmd_addr[OFFW-1:0];
          last_be_d   = {BYTES{1'b1}} >> (OFFW'(BYTES - 1) - end_addr[OFFW-1:0]);
          err_d       = 1'b0;
        end
      end
      ST_RUN: begin
        if (rd_valid && rd_err) begin
          err_d = 1'b1;
        end
        if (req_valid_q) begin
          if (req_ack) begin
            req_valid_d = 1'b0;
            cur_wd_d    = cur_wd_q + WORD_W'(req_beats_q);
            rem_d       = rem_q - CNT_W'(req_beats_q);
            first_d     = 1'b0;
          end
        end else if (rem_q != '0) begin
          if (room) begin
            req_valid_d = 1'b1;
            req_beats_d = plan_beats;
            req_be_d    = plan_be;
          end
        end else if (out_cnt == '0 && !rd_valid) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_wd_q    <= '0;
      rem_q       <= '0;
      first_q     <= 1'b0;
      head_unal_q <= 1'b0;
      tail_unal_q <= 1'b0;
      first_be_q  <= '0;
      last_be_q   <= '0;
      req_valid_q <= 1'b0;
      req_beats_q <= '0;
      req_be_q    <= '0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cur_wd_q    <= cur_wd_d;
      rem_q       <= rem_d;
      first_q     <= first_d;
      head_unal_q <= head_unal_d;
      tail_unal_q <= tail_unal_d;
      first_be_q  <= first_be_d;
      last_be_q   <= last_be_d;
      req_valid_q <= req_valid_d;
      req_beats_q <= req_beats_d;
      req_be_q    <= req_be_d;
      err_q       <= err_d;
      done_q      <= done_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign req_valid = req_valid_q;
  assign req_addr  = {cur_wd_q, {OFFW{1'b0}}};
  assign req_beats = req_beats_q;
  assign req_be    = req_be_q;
  assign buf_wr    = wr_beat;
  assign buf_data  = rd_data;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 16,
  parameter int FREE_W    = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cmd_ready,
  input logic                           req_valid,
  input logic                           req_ack,
  input logic [ADDR_W-1:0]              req_addr,
  input logic [$clog2(MAX_BURST+1)-1:0] req_beats,
  input logic [DATA_W/8-1:0]            req_be,
  input logic [FREE_W-1:0]              buf_free,
  input logic [FREE_W:0]                out_cnt,
  input logic                           done
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_beats) && $stable(req_be)));

  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> !req_valid);

  assert_beat_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats >= 1 && int'(req_beats) <= MAX_BURST));

  assert_burst_full_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_beats > 1) |-> (&req_be));

  assert_single_be_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_beats == 1) |-> (req_be != '0));

  assert_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (int'($past(buf_free)) >= int'(req_beats) + int'($past(out_cnt))));

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind burst_read_splitter brs_checker #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .MAX_BURST (MAX_BURST),
  .FREE_W    (FREE_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .req_valid (req_valid),
  .req_ack   (req_ack),
  .req_addr  (req_addr),
  .req_beats (req_beats),
  .req_be    (req_be),
  .buf_free  (buf_free),
  .out_cnt   (out_cnt),
  .done      (done)
);

// File: tb/burst_read_splitter_tb_top.sv
module burst_read_splitter_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int MAXB   = 16;
  localparam int FREE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic              req_valid;
  logic              req_ack;
  logic [ADDR_W-1:0] req_addr;
  logic [4:0]        req_beats;
  logic [3:0]        req_be;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              rd_err;
  logic              buf_wr;
  logic [DATA_W-1:0] buf_data;
  logic [FREE_W-1:0] buf_free;
  logic              done;
  logic              err;

  always #10 clk = ~clk;

  burst_read_splitter #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAXB), .FREE_W(FREE_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .req_valid(req_valid), .req_ack(req_ack),
    .req_addr(req_addr), .req_beats(req_beats), .req_be(req_be), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .buf_wr(buf_wr), .buf_data(buf_data),
    .buf_free(buf_free), .done(done), .err(err)
  );

  int n_chk  = 0;
  int n_fail = 0;

  int exp_word[$];
  int exp_beats[$];
  int exp_be[$];
  int exp_data[$];

  int beat_no;
  int err_at;
  bit done_seen;
  bit err_seen;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int lanes(input int lo, input int hi);
    int m = 0;
    for (int i = lo; i <= hi; i++) m |= (1 << i);
    return m;
  endfunction

  function automatic logic [31:0] pat(input int w);
    return {w[15:0], ~w[15:0]};
  endfunction

  task automatic push_req(input int w, input int n, input int be);
    exp_word.push_back(w);
    exp_beats.push_back(n);
    exp_be.push_back(be);
    for (int i = 0; i < n; i++) exp_data.push_back(w + i);
  endtask

  // Expected request list from R2..R5 (4-byte words).
  task automatic plan_expect(input int a, input int l);
    int fw, lw, so, eo, w, mend, n;
    fw = a / 4;
    lw = (a + l - 1) / 4;
    so = a % 4;
    eo = (a + l - 1) % 4;
    if (fw == lw) begin
      push_req(fw, 1, lanes(so, eo));
      return;
    end
    w = fw;
    if (so != 0) begin
      push_req(fw, 1, lanes(so, 3));
      w++;
    end
    mend = (eo != 3) ? lw - 1 : lw;
    while (w <= mend) begin
      n = mend - w + 1;
      if (n > MAXB) n = MAXB;
      push_req(w, n, 15);
      w += n;
    end
    if (eo != 3) push_req(lw, 1, lanes(0, eo));
  endtask

  // Bus model: checks each posted request against the scoreboard, then returns data.
  initial begin
    req_ack  = 1'b0;
    rd_valid = 1'b0;
    rd_data  = '0;
    rd_err   = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        if (exp_word.size() == 0) begin
          check(1'b0, "R4", "unexpected request addr", req_addr, 0);
        end else begin
          int w, n, be;
          w  = exp_word.pop_front();
          n  = exp_beats.pop_front();
          be = exp_be.pop_front();
          check(req_addr == ADDR_W'(w * 4), "R4", "request addr", req_addr, w * 4);
          check(int'(req_beats) == n, "R10", "request beats", req_beats, n);
          check(int'(req_be) == be, (n == 1) ? "R3" : "R4", "request byte enables", req_be, be);
          check(int'(buf_free) >= int'(req_beats), "R7", "request posted without room", buf_free, req_beats);
        end
        begin
          int rw, rn;
          rw = int'(req_addr) / 4;
          rn = int'(req_beats);
          req_ack = 1'b1;
          @(negedge clk);
          req_ack = 1'b0;
          check(req_valid == 1'b0, "R6", "valid after ack", req_valid, 0);
          for (int i = 0; i < rn; i++) begin
            rd_valid = 1'b1;
            rd_data  = pat(rw + i);
            rd_err   = (beat_no == err_at);
            beat_no++;
            @(negedge clk);
          end
          rd_valid = 1'b0;
          rd_err   = 1'b0;
        end
      end
    end
  end

  // Monitor: buffer writes and completion.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && buf_wr) begin
        if (exp_data.size() == 0) begin
          check(1'b0, "R8", "unexpected buffer write", buf_data, 0);
        end else begin
          int w;
          w = exp_data.pop_front();
          check(buf_data == pat(w), "R8", "buffer data", buf_data, pat(w));
        end
      end
      if (rst_n && done) begin
        done_seen = 1'b1;
        err_seen  = err;
      end
    end
  end

  task automatic wait_done(input string req, input bit exp_err);
    int t = 0;
    while (!done_seen && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(done_seen, req, "done pulse seen", done_seen, 1);
    check(err_seen == exp_err, "R9", "error status", err_seen, exp_err);
    check(exp_word.size() == 0, req, "requests left unissued", exp_word.size(), 0);
    check(exp_data.size() == 0, "R8", "beats left unwritten", exp_data.size(), 0);
    @(negedge clk);
    check(done == 1'b0 && cmd_ready == 1'b1, "R9", "done one cycle then idle", done, 0);
  endtask

  task automatic start_cmd(input int a, input int l, input int e_at);
    done_seen = 1'b0;
    err_seen  = 1'b0;
    beat_no   = 0;
    err_at    = e_at;
    plan_expect(a, l);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "ready before command", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_addr  = ADDR_W'(a);
    cmd_len   = LEN_W'(l);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R1", "busy after command", cmd_ready, 0);
  endtask

  task automatic run(input int a, input int l, input int e_at, input string req);
    start_cmd(a, l, e_at);
    wait_done(req, e_at >= 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_addr  = '0;
    cmd_len   = '0;
    buf_free  = FREE_W'(64);
    beat_no   = 0;
    err_at    = -1;
    done_seen = 1'b0;
    err_seen  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
    check(req_valid == 1'b0, "R1", "reset req_valid", req_valid, 0);
    check(done == 1'b0 && buf_wr == 1'b0, "R9", "reset done", done, 0);

    run(0, 64, -1, "R4");        // one full burst
    run(32'h102, 70, -1, "R2");  // head single, burst 16, remainder single (R5)
    run(5, 2, -1, "R3");         // inside one word
    run(0, 10, -1, "R3");        // burst 2 then tail single
    run(3, 6, -1, "R5");         // head, one middle word, tail
    run(32'h40, 20, -1, "R4");   // short burst of 5
    run(32'h203, 1000, 37, "R9");// long, error on one beat
    run(32'h11, 45, -1, "R9");   // error cleared by new command

    // R7: starved buffer holds a 16-beat burst back
    buf_free = FREE_W'(3);
    start_cmd(0, 64, -1);
    repeat (40) begin
      @(negedge clk);
      if (req_valid) check(1'b0, "R7", "request without room", req_valid, 0);
    end
    check(exp_word.size() == 1, "R7", "request held back", exp_word.size(), 1);
    buf_free = FREE_W'(16);
    wait_done("R7", 1'b0);

    // R7: room only for one burst at a time with outstanding beats counted
    run(32'h400, 256, -1, "R7");
    buf_free = FREE_W'(64);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule